// File: doc/BRIEF.md
# Sense-Reversing Barrier Controller

This block is a hardware rendezvous point for a fixed group of participants. Each participant pulses its arrive input when it reaches the barrier. It is then held until every member of the group has also arrived. Arrivals that land in the same cycle are all counted. When the last one lands, the shared arrival count returns to zero and a single shared flag inverts. Each participant is released as soon as that flag equals its own local sense bit.

Every participant toggles its local sense bit when it enters an episode, so one counter and one flag serve any number of consecutive episodes. A participant that hurries on to the next episode cannot be let through early: the flag it now needs is the opposite of the value it just saw.

Each participant has a two-state machine, `PT_RUN` and `PT_WAIT`. The transition *enter* (RUN to WAIT) happens on an accepted arrive pulse. The transition *leave* (WAIT to RUN) happens when the shared flag matches the participant's sense. A global phase machine has the states `GB_GATHER` and `GB_DRAIN`. Its transition *complete* (GATHER to DRAIN) fires when the arrival total reaches the group size. Its transition *reopen* (DRAIN to GATHER) fires at the edge where every participant leaves. The arrival counter advances only in GATHER.

Top module: `bsync_barrier`

## Requirements
- R1: After reset the flag output is 0, every sense output is 0 and every go output is 1. The arrival count is zero.
- R2: An arrive pulse from a participant whose go output is 1 is accepted. In the next cycle that participant's sense output is inverted and its go output is 0.
- R3: An arrive pulse from a participant whose go output is 0 is ignored. Its sense output does not change, and it adds nothing to the arrival count, so it cannot bring completion closer.
- R4: All arrivals accepted in one cycle are counted together. The episode completes in the cycle where the running total of accepted arrivals reaches the group size.
- R5: In the cycle after completion, the flag output has inverted and equals the new sense value of every participant, including the last arriver's.
- R6: A participant whose go output is 0 keeps it at 0 for as long as the flag output differs from its sense output.
- R7: Every go output rises in the cycle after the flag output changes. Each go output then stays at 1 until that participant's next accepted arrival.
- R8: Completion resets the arrival count to zero. The next episode therefore needs the full group size of fresh arrivals before the flag inverts again.
- R9: In the cycle when the flag output has just changed, every participant is still leaving the waiting state, and any arrive pulses in that cycle are ignored. No arrival of the next episode is accepted until every participant has left the waiting state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| arrive_i | input | NUM_PART | One-cycle arrival pulse, one bit per participant |
| sense_o | output | NUM_PART | Local sense bit of each participant |
| go_o | output | NUM_PART | 1 when the participant is released (not waiting) |
| flag_o | output | 1 | Shared release flag |

## Verification
The bench builds the block with four participants, so the arrival counter is three bits wide. The bench splits an episode into single arrivals, a pair in one cycle and all four in one cycle. It repeats an arrive pulse from a participant that is already waiting, and it pulses arrive from everyone in the one-cycle release window. It also runs two episodes back to back, so that early arrivers of the next episode meet a counter that has just been cleared.

// File: rtl/bsync_pkg.sv
package bsync_pkg;

    // Per-participant state: free to run, or parked at the barrier.
    typedef enum logic {
        PT_RUN  = 1'b0,
        PT_WAIT = 1'b1
    } part_state_t;

    // Global phase: collecting arrivals, or letting the group leave.
    typedef enum logic {
        GB_GATHER = 1'b0,
        GB_DRAIN  = 1'b1
    } phase_t;

endpackage

// File: rtl/bsync_part.sv
module bsync_part
    import bsync_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arrive,
    input  logic flag,
    output logic accept,
    output logic leaving,
    output logic sense,
    output logic go
);

    part_state_t st_q, st_d;
    logic        sense_q, sense_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= PT_RUN;
            sense_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            sense_q <= sense_d;
        end
    end

    // Next state: enter on accepted arrival, leave when flag matches sense
    always_comb begin
        st_d    = st_q;
        sense_d = sense_q;
        unique case (st_q)
            PT_RUN: begin
                if (arrive) begin
                    st_d    = PT_WAIT;
                    sense_d = ~sense_q;
                end
            end
            PT_WAIT: begin
                if (flag == sense_q) begin
                    st_d = PT_RUN;
                end
            end
            default: st_d = PT_RUN;
        endcase
    end

    // Outputs
    always_comb begin
        accept  = (st_q == PT_RUN) && arrive;
        leaving = (st_q == PT_WAIT) && (flag == sense_q);
        sense   = sense_q;
        go      = (st_q == PT_RUN);
    end

    AST_ACCEPT_TOGGLES: assert property (@(posedge clk) disable iff (!rst_n)
        (go && arrive) |=> (sense != $past(sense)) && !go) else $error("accept"); // R2

    AST_WAIT_SENSE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!go) |=> $stable(sense)) else $error("dup arrive changed sense"); // R3

    AST_WAIT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && (flag != sense)) |=> !go) else $error("early release"); // R6

    AST_GO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !arrive) |=> go) else $error("go dropped"); // R7

endmodule

// File: rtl/bsync_count.sv
module bsync_count #(
    parameter int NUM_PART = 4,
    localparam int CW = $clog2(NUM_PART + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en,
    input  logic [NUM_PART-1:0] accept,
    output logic                done,
    output logic [CW-1:0]       cnt
);

    logic [CW-1:0] cnt_q, cnt_d, pop, total;

    always_comb begin
        pop = '0;
        for (int i = 0; i < NUM_PART; i++) begin
            pop = pop + CW'(accept[i]);
        end
    end

    always_comb begin
        total = cnt_q + pop;
        done  = en && (total == CW'(NUM_PART));
        if (!en)       cnt_d = cnt_q;
        else if (done) cnt_d = '0;
        else           cnt_d = total;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(NUM_PART)) else $error("count overflow"); // R4

    AST_CLEAR_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (cnt_q == '0)) else $error("count not cleared"); // R8

endmodule

// File: rtl/bsync_barrier.sv
module bsync_barrier
    import bsync_pkg::*;
#(
    parameter int NUM_PART = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PART-1:0] arrive_i,
    output logic [NUM_PART-1:0] sense_o,
    output logic [NUM_PART-1:0] go_o,
    output logic                flag_o
);

    localparam int CW = $clog2(NUM_PART + 1);

    logic [NUM_PART-1:0] accept, leaving, sense_v, go_v;
    logic                done;
    logic [CW-1:0]       cnt;
    phase_t              ph_q, ph_d;
    logic                flag_q, flag_d;

    for (genvar g = 0; g < NUM_PART; g++) begin : g_part
        bsync_part u_part (
            .clk     (clk),
            .rst_n   (rst_n),
            .arrive  (arrive_i[g]),
            .flag    (flag_q),
            .accept  (accept[g]),
            .leaving (leaving[g]),
            .sense   (sense_v[g]),
            .go      (go_v[g])
        );
    end

    bsync_count #(.NUM_PART(NUM_PART)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (ph_q == GB_GATHER),
        .accept (accept),
        .done   (done),
        .cnt    (cnt)
    );

    // Phase and flag register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q   <= GB_GATHER;
            flag_q <= 1'b0;
        end else begin
            ph_q   <= ph_d;
            flag_q <= flag_d;
        end
    end

    // Phase transitions: complete and reopen
    always_comb begin
        ph_d   = ph_q;
        flag_d = flag_q;
        unique case (ph_q)
            GB_GATHER: begin
                if (done) begin
                    ph_d   = GB_DRAIN;
                    flag_d = ~flag_q;
                end
            end
            GB_DRAIN: begin
                if (&leaving) ph_d = GB_GATHER;
            end
            default: ph_d = GB_GATHER;
        endcase
    end

    // Outputs
    always_comb begin
        sense_o = sense_v;
        go_o    = go_v;
        flag_o  = flag_q;
    end

    AST_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == GB_DRAIN) |-> (accept == '0)) else $error("arrival during drain"); // R9

    AST_FLAG_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == GB_DRAIN) |-> (sense_v == {NUM_PART{flag_q}})) else $error("flag mismatch"); // R5

    AST_ALL_GO: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(flag_q) |=> (go_v == '1)) else $error("release missing"); // R7

    AST_FLAG_ONLY_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !done |=> $stable(flag_q)) else $error("spurious flip"); // R8

    AST_COUNT_ZERO_IN_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == GB_DRAIN) |-> (cnt == '0)) else $error("stale count"); // R8

endmodule

// File: tb/bsync_barrier_tb_top.sv
module bsync_barrier_tb_top;

    localparam int P = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [P-1:0] arrive = '0;
    logic [P-1:0] sense, go;
    logic         flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done_run = 0;

    typedef struct {
        logic         flag;
        logic [P-1:0] sense;
        logic [P-1:0] go;
        string        tag;
    } exp_t;

    exp_t q[$];

    // Requirement-based model state
    logic         m_flag = 1'b0;
    logic [P-1:0] m_sense = '0;
    logic [P-1:0] m_wait = '0;
    int           m_cnt = 0;

    always #10 clk = ~clk;

    bsync_barrier #(.NUM_PART(P)) dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .arrive_i (arrive),
        .sense_o  (sense),
        .go_o     (go),
        .flag_o   (flag)
    );

    task automatic check1(input string tag, input string what,
                          input logic [P-1:0] act, input logic [P-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Driver: apply one cycle of arrivals and push the expected outcome
    task automatic step(input logic [P-1:0] a, input string tag);
        logic [P-1:0] nw, ns, acc;
        logic         nf;
        int           pop;
        exp_t         e;
        @(negedge clk);
        arrive = a;
        nw = m_wait;
        ns = m_sense;
        nf = m_flag;
        for (int i = 0; i < P; i++) begin
            if (m_wait[i] && (m_sense[i] == m_flag)) nw[i] = 1'b0;
        end
        acc = a & ~m_wait;
        pop = 0;
        for (int i = 0; i < P; i++) begin
            if (acc[i]) begin
                ns[i] = ~m_sense[i];
                nw[i] = 1'b1;
                pop++;
            end
        end
        m_cnt = m_cnt + pop;
        if (m_cnt == P) begin
            m_cnt = 0;
            nf = ~m_flag;
        end
        m_wait  = nw;
        m_sense = ns;
        m_flag  = nf;
        e.flag  = nf;
        e.sense = ns;
        e.go    = ~nw;
        e.tag   = tag;
        q.push_back(e);
    endtask

    // Monitor: compare results a quarter period after each edge
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check1(e.tag, "flag", {{(P-1){1'b0}}, flag}, {{(P-1){1'b0}}, e.flag});
                check1(e.tag, "sense", sense, e.sense);
                check1(e.tag, "go", go, e.go);
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000 && !done_run) begin
                errors++;
                $display("FAIL watchdog actual=%0d expected<=5000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check1("R1", "flag", {{(P-1){1'b0}}, flag}, '0);
        check1("R1", "sense", sense, '0);
        check1("R1", "go", go, '1);
        rst_n = 1'b1;
        step(4'b0000, "R1");

        // Episode 1: single, duplicate, single, idle, pair completes
        step(4'b0001, "R2");
        step(4'b0001, "R3");
        step(4'b0010, "R6");
        step(4'b0000, "R6");
        step(4'b1100, "R5");
        step(4'b0000, "R7");
        step(4'b0000, "R7");

        // Episode 2: all at once, then arrivals in the release window
        step(4'b1111, "R4");
        step(4'b1111, "R9");
        step(4'b0000, "R7");

        // Episodes 3 and 4 back to back
        step(4'b0011, "R8");
        step(4'b0100, "R8");
        step(4'b1000, "R5");
        step(4'b0011, "R9");
        step(4'b0011, "R8");
        step(4'b0100, "R8");
        step(4'b0000, "R6");
        step(4'b1000, "R5");
        step(4'b0000, "R7");
        step(4'b0000, "R7");

        @(negedge clk);
        arrive = '0;
        repeat (2) @(negedge clk);
        done_run = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule